// File: doc/BRIEF.md
# Crosspoint Configuration Loader and Word Matrix

This block is a word-wide crosspoint of sixteen ports. Every output port carries the 34-bit word of one chosen input port. An output can instead carry a fixed IDLE word when its force-idle flag is set. Several outputs may take the same input, so one input can fan out to many outputs.

The connection map arrives on a parallel configuration interface. It takes four consecutive write beats, and each beat carries four 4-bit input selections and four force-idle flags. The ports in each beat are interleaved: a beat covers two ports from the lower half and the matching two ports from the upper half. A completed four-beat sequence goes into a shadow map. The shadow map moves into the active matrix only on a cell-clock pulse, and only once the required settling gap after the last beat has passed.

The switched words are a free-running, fixed-rate link with one word per port on every clock cycle. There is no valid/ready handshake and no back-pressure. A word taken in at one clock edge appears at the output on the next edge.

Top module: `xpt_switch`

## Requirements
- R1: While reset is held, and after it is released until a map is applied, every output carries the IDLE word (34'h1_5A5A_A5A5). The reset map selects input 0 with force-idle set on every output.
- R2: In write beat k (0..3), `cfg_data` bits [3:0], [7:4], [11:8] and [15:12] are the input selections of output ports 2k, 2k+1, 8+2k and 9+2k.
- R3: In write beat k, `cfg_fidle` bits 0, 1, 2 and 3 are the force-idle flags of output ports 2k, 2k+1, 8+2k and 9+2k.
- R4: Under the active map, an output without force-idle carries the word that its selected input had one clock earlier. Any number of outputs may select the same input.
- R5: Under the active map, an output with force-idle set carries the IDLE word whatever its input selection is.
- R6: A completed sequence changes nothing at the outputs until a cell-clock pulse applies it. A cell-clock pulse with no completed sequence pending changes nothing.
- R7: Let the last beat be sampled at clock edge t. A cell-clock pulse sampled at edge t+n applies the pending map only if n >= 6, which leaves at least 5 cycles between them. An earlier pulse is ignored and the map stays pending for a later pulse.
- R8: If write enable drops before the fourth beat, the partial sequence is discarded. The shadow map and the pending state stay as they were, and the next beat starts again at beat 0.
- R9: When a second complete sequence finishes before the pending map is applied, it replaces the pending map and restarts the settling gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable, held for consecutive beats |
| cfg_data | input | 16 | Four input selections of the current beat |
| cfg_fidle | input | 4 | Four force-idle flags of the current beat |
| cell_clk | input | 1 | Cell boundary pulse; the pending map is applied here |
| in_words | input | 544 | Input port words, port p at bits [34p+33:34p] |
| out_words | output | 544 | Output port words, port p at bits [34p+33:34p] |

## Verification
The word path has one register. After each cell-clock pulse the bench drives fresh inputs on the next falling edge and compares all sixteen outputs on the falling edge after that, when one rising edge has passed. The map update uses the edge that samples `cell_clk`, and that same edge still loads the outputs from the old map. The settling gap is counted in rising edges from the edge that samples the last beat. The bench places pulses exactly 5 edges after it (too early) and exactly 6 edges after it (the earliest legal edge). It also checks outputs between staging and applying, to confirm that a staged map stays invisible until a pulse applies it.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam logic [33:0] XPT_IDLE_DEFAULT = 34'h1_5A5A_A5A5;
  localparam int unsigned XPT_LANES = 4;

  // Output port addressed by lane j (0..3) of beat k: two low-half ports, then two high-half ports.
  function automatic int unsigned beat_port(int unsigned k, int unsigned j, int unsigned nports);
    return ((j >= 2) ? nports / 2 : 0) + 2 * k + (j % 2);
  endfunction
endpackage

// File: rtl/xpt_cfg_loader.sv
module xpt_cfg_loader
  import xpt_pkg::*;
#(
  parameter int NPORTS = 16,
  parameter int SEL_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [XPT_LANES*SEL_W-1:0] cfg_data,
  input  logic [XPT_LANES-1:0]      cfg_fidle,
  output logic [NPORTS*SEL_W-1:0]   shd_sel,
  output logic [NPORTS-1:0]         shd_fi,
  output logic                      seq_done
);
  localparam int NBEATS = NPORTS / XPT_LANES;
  localparam int BW     = (NBEATS > 1) ? $clog2(NBEATS) : 1;

  logic [BW-1:0]             beat_q;
  logic [NPORTS*SEL_W-1:0]   stg_sel, mrg_sel;
  logic [NPORTS-1:0]         stg_fi, mrg_fi;
  logic                      last_beat;

  assign last_beat = (beat_q == BW'(NBEATS - 1));
  assign seq_done  = cfg_we && last_beat;

  // Overlay the current beat on the staging buffer.
  always_comb begin
    mrg_sel = stg_sel;
    mrg_fi  = stg_fi;
    for (int j = 0; j < XPT_LANES; j++) begin
      mrg_sel[beat_port(32'(beat_q), j, NPORTS)*SEL_W +: SEL_W] = cfg_data[j*SEL_W +: SEL_W];
      mrg_fi[beat_port(32'(beat_q), j, NPORTS)]               = cfg_fidle[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q  <= '0;
      stg_sel <= '0;
      stg_fi  <= '1;
      shd_sel <= '0;
      shd_fi  <= '1;
    end else if (cfg_we) begin
      stg_sel <= mrg_sel;
      stg_fi  <= mrg_fi;
      if (last_beat) begin
        shd_sel <= mrg_sel;
        shd_fi  <= mrg_fi;
        beat_q  <= '0;
      end else begin
        beat_q <= beat_q + BW'(1);
      end
    end else begin
      beat_q <= '0;
    end
  end
endmodule

// File: rtl/xpt_map_commit.sv
module xpt_map_commit #(
  parameter int NPORTS  = 16,
  parameter int SEL_W   = 4,
  parameter int MIN_GAP = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seq_done,
  input  logic                    cell_clk,
  input  logic [NPORTS*SEL_W-1:0] shd_sel,
  input  logic [NPORTS-1:0]       shd_fi,
  output logic [NPORTS*SEL_W-1:0] act_sel,
  output logic [NPORTS-1:0]       act_fi,
  output logic                    pending,
  output logic                    gap_ok
);
  localparam int GW = $clog2(MIN_GAP + 1);

  logic [GW-1:0] gap_cnt;
  logic          apply;

  assign gap_ok = (gap_cnt >= GW'(MIN_GAP));
  assign apply  = cell_clk && pending && gap_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      pending <= 1'b0;
      act_sel <= '0;
      act_fi  <= '1;
    end else begin
      if (seq_done) begin
        gap_cnt <= '0;
        pending <= 1'b1;
      end else begin
        if (!gap_ok) gap_cnt <= gap_cnt + GW'(1);
        if (apply)   pending <= 1'b0;
      end
      if (apply) begin
        act_sel <= shd_sel;
        act_fi  <= shd_fi;
      end
    end
  end
endmodule

// File: rtl/xpt_matrix.sv
module xpt_matrix #(
  parameter int          NPORTS = 16,
  parameter int          SEL_W  = 4,
  parameter int          WORD_W = 34,
  parameter logic [WORD_W-1:0] IDLE_WORD = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS*SEL_W-1:0]  act_sel,
  input  logic [NPORTS-1:0]        act_fi,
  input  logic [NPORTS*WORD_W-1:0] in_words,
  output logic [NPORTS*WORD_W-1:0] out_words
);
  for (genvar o = 0; o < NPORTS; o++) begin : g_out
    logic [SEL_W-1:0] sel;
    assign sel = act_sel[o*SEL_W +: SEL_W];
    always_ff @(posedge clk) begin
      if (!rst_n)
        out_words[o*WORD_W +: WORD_W] <= IDLE_WORD;
      else if (act_fi[o])
        out_words[o*WORD_W +: WORD_W] <= IDLE_WORD;
      else
        out_words[o*WORD_W +: WORD_W] <= in_words[sel*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/xpt_switch.sv
module xpt_switch
  import xpt_pkg::*;
#(
  parameter int          NPORTS  = 16,
  parameter int          SEL_W   = 4,
  parameter int          WORD_W  = 34,
  parameter int          MIN_GAP = 5,
  parameter logic [WORD_W-1:0] IDLE_WORD = XPT_IDLE_DEFAULT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [XPT_LANES*SEL_W-1:0]  cfg_data,
  input  logic [XPT_LANES-1:0]        cfg_fidle,
  input  logic                        cell_clk,
  input  logic [NPORTS*WORD_W-1:0]    in_words,
  output logic [NPORTS*WORD_W-1:0]    out_words
);
  logic [NPORTS*SEL_W-1:0] shd_sel, act_sel;
  logic [NPORTS-1:0]       shd_fi, act_fi;
  logic                    seq_done, pending, gap_ok;

  xpt_cfg_loader #(.NPORTS(NPORTS), .SEL_W(SEL_W)) u_load (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .cfg_fidle(cfg_fidle), .shd_sel(shd_sel), .shd_fi(shd_fi), .seq_done(seq_done)
  );

  xpt_map_commit #(.NPORTS(NPORTS), .SEL_W(SEL_W), .MIN_GAP(MIN_GAP)) u_commit (
    .clk(clk), .rst_n(rst_n), .seq_done(seq_done), .cell_clk(cell_clk),
    .shd_sel(shd_sel), .shd_fi(shd_fi), .act_sel(act_sel), .act_fi(act_fi),
    .pending(pending), .gap_ok(gap_ok)
  );

  xpt_matrix #(.NPORTS(NPORTS), .SEL_W(SEL_W), .WORD_W(WORD_W), .IDLE_WORD(IDLE_WORD)) u_mtx (
    .clk(clk), .rst_n(rst_n), .act_sel(act_sel), .act_fi(act_fi),
    .in_words(in_words), .out_words(out_words)
  );
endmodule

// File: rtl/xpt_switch_chk.sv
module xpt_switch_chk #(
  parameter int          NPORTS = 16,
  parameter int          SEL_W  = 4,
  parameter int          WORD_W = 34,
  parameter logic [WORD_W-1:0] IDLE_WORD = '0
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cell_clk,
  input logic                     seq_done,
  input logic                     pending,
  input logic                     gap_ok,
  input logic [NPORTS*SEL_W-1:0]  shd_sel,
  input logic [NPORTS-1:0]        shd_fi,
  input logic [NPORTS*SEL_W-1:0]  act_sel,
  input logic [NPORTS-1:0]        act_fi,
  input logic [NPORTS*WORD_W-1:0] out_words
);
  // R6: the active map moves only on an edge that samples the cell pulse
  p_map_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_clk |=> ($stable(act_sel) && $stable(act_fi)));

  // R7: a pulse inside the settling gap leaves the active map alone
  p_gap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_clk && pending && !gap_ok) |=> ($stable(act_sel) && $stable(act_fi)));

  // R8: the shadow map only changes when a full sequence completes
  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_done |=> ($stable(shd_sel) && $stable(shd_fi)));

  // R9: an applied map is no longer pending unless a new one completed at once
  p_pending_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_clk && pending && gap_ok && !seq_done) |=> !pending);

  // R5: forced outputs carry IDLE
  for (genvar o = 0; o < NPORTS; o++) begin : g_fi
    p_fidle_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(act_fi[o]) |-> (out_words[o*WORD_W +: WORD_W] == IDLE_WORD));
  end
endmodule

bind xpt_switch xpt_switch_chk #(
  .NPORTS(NPORTS), .SEL_W(SEL_W), .WORD_W(WORD_W), .IDLE_WORD(IDLE_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cell_clk(cell_clk), .seq_done(seq_done),
  .pending(pending), .gap_ok(gap_ok), .shd_sel(shd_sel), .shd_fi(shd_fi),
  .act_sel(act_sel), .act_fi(act_fi), .out_words(out_words)
);

// File: tb/xpt_switch_test.sv
module xpt_switch_test;
  localparam int NP = 16;
  localparam int WW = 34;
  localparam logic [33:0] IDLE = 34'h1_5A5A_A5A5;

  // {selects (port p at [4p+3:4p]), force-idle flags (port p at bit p)}
  localparam logic [79:0] VEC [0:3] = '{
    {64'hFEDC_BA98_7654_3210, 16'h0000},
    {64'h0123_4567_89AB_CDEF, 16'h0000},
    {64'h5555_5555_5555_5555, 16'h8001},
    {64'h3C3C_A5F0_0F5A_1234, 16'h0A50}
  };

  logic clk = 0, rst_n = 0, cfg_we = 0, cell_clk = 0;
  logic [15:0] cfg_data = '0;
  logic [3:0]  cfg_fidle = '0;
  logic [NP*WW-1:0] in_words = '0, out_words;
  int checks = 0, fails = 0;
  logic [3:0] exp_sel [NP];
  logic       exp_fi  [NP];

  always #5 clk = ~clk;

  xpt_switch uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .cfg_fidle(cfg_fidle), .cell_clk(cell_clk), .in_words(in_words), .out_words(out_words)
  );

  function automatic logic [33:0] in_word(int p, int seed);
    logic [31:0] pp = 32'(p);
    logic [31:0] ss = 32'(seed);
    return {pp[1:0], ss * 32'h0001_0003 + pp * 32'h0101_0011};
  endfunction

  task automatic drive_in(int seed);
    for (int p = 0; p < NP; p++) in_words[p*WW +: WW] = in_word(p, seed);
  endtask

  task automatic check(string tag, int seed);
    for (int o = 0; o < NP; o++) begin
      logic [33:0] e = exp_fi[o] ? IDLE : in_word(int'(exp_sel[o]), seed);
      checks++;
      if (out_words[o*WW +: WW] !== e) begin
        fails++;
        $display("FAIL %s port %0d: got %h expected %h", tag, o, out_words[o*WW +: WW], e);
      end
    end
  endtask

  // R2/R3 beat layout: lanes map to ports 2k, 2k+1, 8+2k, 9+2k
  task automatic wr_map(logic [79:0] v, int nbeats);
    for (int k = 0; k < nbeats; k++) begin
      @(negedge clk);
      cfg_we = 1;
      cfg_data  = {v[16+(9+2*k)*4 +: 4], v[16+(8+2*k)*4 +: 4], v[16+(2*k+1)*4 +: 4], v[16+(2*k)*4 +: 4]};
      cfg_fidle = {v[9+2*k], v[8+2*k], v[2*k+1], v[2*k]};
    end
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse();
    @(negedge clk); cell_clk = 1;
    @(negedge clk); cell_clk = 0;
  endtask

  task automatic set_exp(logic [79:0] v);
    for (int p = 0; p < NP; p++) begin
      exp_sel[p] = v[16+p*4 +: 4];
      exp_fi[p]  = v[p];
    end
  endtask

  task automatic pulse_check(string tag, int seed);
    pulse();
    drive_in(seed);
    @(negedge clk);
    check(tag, seed);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    set_exp({64'h0, 16'hFFFF});
    drive_in(1);
    repeat (3) @(negedge clk);
    check("R1 during reset", 1);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 1);
    pulse_check("R6 pulse with nothing pending", 2);

    // table walk: stage, confirm old map still active, apply at minimum legal gap
    for (int i = 0; i < 4; i++) begin
      wr_map(VEC[i], 4);
      drive_in(10 + i);
      @(negedge clk);
      check("R6 staged map not visible", 10 + i);
      repeat (3) @(negedge clk);
      set_exp(VEC[i]);
      pulse_check("R2/R3/R4/R5 applied map", 20 + i);
    end

    // R7: pulse 5 edges after the last beat is ignored, later one applies
    wr_map(VEC[0], 4);
    repeat (3) @(negedge clk);
    pulse_check("R7 early pulse ignored", 30);
    repeat (2) @(negedge clk);
    set_exp(VEC[0]);
    pulse_check("R7 deferred apply", 31);

    // R8: partial sequence after a complete one leaves the pending map intact
    wr_map(VEC[1], 4);
    wr_map(VEC[3], 2);
    repeat (6) @(negedge clk);
    set_exp(VEC[1]);
    pulse_check("R8 partial discarded", 40);

    // R8: partial sequence alone makes nothing pending
    wr_map(VEC[2], 3);
    repeat (6) @(negedge clk);
    pulse_check("R8 partial not applied", 41);

    // R9: second full sequence replaces the pending one
    wr_map(VEC[2], 4);
    wr_map(VEC[3], 4);
    repeat (4) @(negedge clk);
    set_exp(VEC[3]);
    pulse_check("R9 pending overwritten", 50);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule